// File: doc/BRIEF.md
# Selectable Arithmetic Logic Unit

This block is a purely combinational arithmetic and logic unit of parameterized width. It takes two operands and a four-bit function code and returns a result word and a carry-out. It has no registers, so the result follows the inputs within the same cycle. It is meant to sit inside a datapath between the operand selectors and the writeback selector.

All eight arithmetic functions come from one ripple adder. The adder's first input is operand A. Its second input is operand B after a conditioning stage, which forces that input to zero, to B, to the complement of B or to all ones. The carry-in bit of the function code is added in. A separate logic path forms AND, OR, XOR or NOT A through a four-way selector. A final two-way selector, steered by the mode bit, picks the path that drives the result.

The design has no state machine. The function code is decoded into a packed struct and two enumerated selector types, and each selector is a `unique case` over its enum.

Top module: `sel_alu`

## Requirements
- R1: The function code `fsel_i` is read as {mode, op1, op0, cin}, with bit 3 as the mode bit and bit 0 as the carry-in. Mode 0 selects the arithmetic path and mode 1 selects the logic path.
- R2: In arithmetic mode, op1 op0 (bits 2:1) set the adder's second input: 00 gives all zeros, 01 gives B, 10 gives the bitwise complement of B, and 11 gives all ones. The result is A + that input + cin, taken modulo 2^WIDTH.
- R3: In arithmetic mode, {cout_o, g_o} equals the full (WIDTH+1)-bit sum A + conditioned B + cin, so cout_o is the carry out of the most significant stage.
- R4: Code 0000 passes A through with cout_o = 0. Code 0111 also passes A through, with cout_o = 1.
- R5: Code 0001 gives A+1. For A equal to all ones, this yields zero with cout_o = 1.
- R6: Code 0101 gives A-B, and cout_o = 1 exactly when A >= B (unsigned). Code 0100 gives A + ~B, which is one less than A-B.
- R7: Code 0110 gives A-1. For A equal to zero, this yields all ones with cout_o = 0.
- R8: In logic mode, bits 1:0 pick the operation: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, and 11 gives NOT A. Bit 2 has no effect on the outputs in logic mode.
- R9: In logic mode, cout_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| fsel_i | input | 4 | Function code {mode, op1, op0, cin} |
| g_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry-out: adder MSB carry in arithmetic mode, 0 in logic mode |

## Verification
The assertions are immediate checks inside combinational processes. They take for granted that operands and function code hold known values, and each one is skipped while any input is still unknown. The stimulus never drives X or Z: it sets all inputs together once per clock, from a fixed-seed generator and from a directed sweep of every code over zero, all ones, MSB-only and alternating operands. It then samples the outputs half a period later, when the combinational paths have settled.

// File: rtl/sel_alu_pkg.sv
package sel_alu_pkg;

    typedef enum logic [1:0] {
        YSRC_ZERO = 2'b00,
        YSRC_B    = 2'b01,
        YSRC_NOTB = 2'b10,
        YSRC_ONES = 2'b11
    } ysrc_e;

    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_OR  = 2'b01,
        LOP_XOR = 2'b10,
        LOP_NOT = 2'b11
    } lop_e;

    typedef struct packed {
        logic       logic_mode;
        logic [1:0] op;
        logic       cin;
    } fsel_t;

endpackage

// File: rtl/alu_bcond.sv
module alu_bcond
    import sel_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  ysrc_e             sel,
    input  logic [WIDTH-1:0]  b,
    output logic [WIDTH-1:0]  y
);
    always_comb begin
        unique case (sel)
            YSRC_ZERO: y = '0;
            YSRC_B:    y = b;
            YSRC_NOTB: y = ~b;
            YSRC_ONES: y = '1;
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/alu_bit_stage.sv
module alu_bit_stage (
    input  logic a,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    always_comb begin
        s  = a ^ y ^ ci;
        co = (a & y) | (ci & (a ^ y));
    end
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] y,
    input  logic             ci,
    output logic [WIDTH-1:0] s,
    output logic             co
);
    localparam int SUMW = WIDTH + 1;

    logic [WIDTH:0] carry;

    assign carry[0] = ci;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        alu_bit_stage u_stage (
            .a  (a[i]),
            .y  (y[i]),
            .ci (carry[i]),
            .s  (s[i]),
            .co (carry[i+1])
        );
    end

    assign co = carry[WIDTH];

    // R3: the chained stages must form the full-width sum
    always_comb begin
        if (!$isunknown({a, y, ci})) begin
            a_r3_ripple_sum: assert ({co, s} ==
                ({1'b0, a} + {1'b0, y} + SUMW'(ci)))
                else $error("ripple sum mismatch");
        end
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import sel_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  lop_e             op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] r
);
    always_comb begin
        unique case (op)
            LOP_AND: r = a & b;
            LOP_OR:  r = a | b;
            LOP_XOR: r = a ^ b;
            LOP_NOT: r = ~a;
            default: r = '0;
        endcase
    end
endmodule

// File: rtl/sel_alu.sv
module sel_alu
    import sel_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       fsel_i,
    output logic [WIDTH-1:0] g_o,
    output logic             cout_o
);
    localparam logic [WIDTH-1:0] ONES = '1;

    fsel_t            fs;
    ysrc_e            ysrc;
    lop_e             lop;
    logic [WIDTH-1:0] y_cond;
    logic [WIDTH-1:0] arith_sum;
    logic             arith_co;
    logic [WIDTH-1:0] logic_res;

    // R1: field order {mode, op1, op0, cin}
    assign fs   = fsel_t'(fsel_i);
    assign ysrc = ysrc_e'(fs.op);
    // R8: logic op from the low two bits, op1 unused
    assign lop  = lop_e'({fs.op[0], fs.cin});

    alu_bcond #(.WIDTH(WIDTH)) u_bcond (
        .sel (ysrc),
        .b   (b_i),
        .y   (y_cond)
    );

    alu_ripple #(.WIDTH(WIDTH)) u_ripple (
        .a  (a_i),
        .y  (y_cond),
        .ci (fs.cin),
        .s  (arith_sum),
        .co (arith_co)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .op (lop),
        .a  (a_i),
        .b  (b_i),
        .r  (logic_res)
    );

    always_comb begin
        if (fs.logic_mode) begin
            g_o    = logic_res;
            cout_o = 1'b0;
        end else begin
            g_o    = arith_sum;
            cout_o = arith_co;
        end
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, fsel_i})) begin
            if (fsel_i[3]) begin
                a_r9_cout_logic: assert (cout_o == 1'b0)
                    else $error("carry-out set in logic mode");
            end
            if (fsel_i == 4'b0000) begin
                a_r4_pass_plain: assert (g_o == a_i && !cout_o)
                    else $error("0000 transfer wrong");
            end
            if (fsel_i == 4'b0111) begin
                a_r4_pass_carry: assert (g_o == a_i && cout_o)
                    else $error("0111 transfer wrong");
            end
            if (fsel_i == 4'b0001) begin
                a_r5_increment: assert (g_o == a_i + 1'b1 && cout_o == (a_i == ONES))
                    else $error("increment wrong");
            end
            if (fsel_i == 4'b0101) begin
                a_r6_subtract: assert (g_o == a_i - b_i && cout_o == (a_i >= b_i))
                    else $error("subtract wrong");
            end
            if (fsel_i == 4'b0110) begin
                a_r7_decrement: assert (g_o == a_i - 1'b1 && cout_o == (a_i != '0))
                    else $error("decrement wrong");
            end
        end
    end
endmodule

// File: tb/sel_alu_tb.sv
module sel_alu_tb;
    localparam int W      = 8;
    localparam int PERIOD = 10;
    localparam int NRAND  = 3000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b;
    logic [3:0]   f;
    logic [W-1:0] g;
    logic         cout;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done  = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    sel_alu #(.WIDTH(W)) u_dut (
        .a_i    (a),
        .b_i    (b),
        .fsel_i (f),
        .g_o    (g),
        .cout_o (cout)
    );

    function automatic logic [W:0] model(logic [W-1:0] x, logic [W-1:0] z, logic [3:0] c);
        logic [W-1:0] yy;
        if (c[3]) begin
            case (c[1:0])
                2'b00:   return {1'b0, x & z};
                2'b01:   return {1'b0, x | z};
                2'b10:   return {1'b0, x ^ z};
                default: return {1'b0, ~x};
            endcase
        end
        case (c[2:1])
            2'b00:   yy = '0;
            2'b01:   yy = z;
            2'b10:   yy = ~z;
            default: yy = '1;
        endcase
        return {1'b0, x} + {1'b0, yy} + (W+1)'(c[0]);
    endfunction

    function automatic string tag(logic [3:0] c);
        if (c[3]) return "R8/R9";
        case (c)
            4'b0000, 4'b0111: return "R4";
            4'b0001:          return "R5";
            4'b0101, 4'b0100: return "R6";
            4'b0110:          return "R7";
            default:          return "R2/R3";
        endcase
    endfunction

    task automatic apply(logic [W-1:0] x, logic [W-1:0] z, logic [3:0] c, string req);
        logic [W:0] exp_v;
        @(posedge clk);
        a = x; b = z; f = c;
        @(negedge clk);
        exp_v = model(x, z, c);
        n_chk++;
        if ({cout, g} !== exp_v) begin
            n_bad++;
            $display("FAIL %s code=%b a=%h b=%h got cout=%b g=%h exp cout=%b g=%h",
                     req, c, x, z, cout, g, exp_v[W], exp_v[W-1:0]);
        end
    endtask

    initial begin
        logic [W-1:0] corners [4];
        int unsigned  seed;
        corners[0] = '0;
        corners[1] = '1;
        corners[2] = {1'b1, {(W-1){1'b0}}};
        corners[3] = {(W/2){2'b10}};
        seed = 32'd1357;
        a = '0; b = '0; f = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        apply('0, '0, 4'b0000, "R1 idle zero");
        apply('1, 8'h00, 4'b0001, "R5 wrap");
        apply('0, 8'h55, 4'b0110, "R7 zero dec");
        apply(8'h30, 8'h30, 4'b0101, "R6 equal");
        apply(8'h10, 8'h30, 4'b0101, "R6 borrow");
        apply(8'h3c, 8'h0f, 4'b0100, "R6 A+~B");
        apply(8'hc3, 8'h99, 4'b0111, "R4 carry pass");
        apply(8'hf0, 8'h33, 4'b1000, "R8 AND op1=0");
        apply(8'hf0, 8'h33, 4'b1100, "R8 AND op1=1");
        apply(8'hf0, 8'h33, 4'b1011, "R8 NOT op1=0");
        apply(8'hf0, 8'h33, 4'b1111, "R8 NOT op1=1");
        apply('1, '1, 4'b1001, "R9 OR all ones");
        apply(8'h80, 8'h80, 4'b0010, "R3 MSB carry");

        for (int c = 0; c < 16; c++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    apply(corners[i], corners[j], 4'(c), tag(4'(c)));

        for (int k = 0; k < NRAND; k++) begin
            logic [W-1:0] rx, rz;
            logic [3:0]   rc;
            rx = W'($urandom(seed));
            seed = seed + 32'd7919;
            rz = W'($urandom(seed));
            seed = seed + 32'd104729;
            rc = 4'($urandom(seed));
            seed = seed + 32'd31;
            apply(rx, rz, rc, tag(rc));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired got running exp done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule